// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block collects eight event sources from a serial bus controller into a latched status word. Each status bit is qualified by a matching enable bit, and the result drives one interrupt line. A single global-enable bit can hold that line low without disturbing the status or enable contents. Software clears status bits by writing ones to them.

All registers sit on a simple 32-bit register bus. The bus has a write strobe, a byte address and write data, and its read data is a combinational function of the address. A key register resets the core: writing a fixed value to it clears every register here and raises a one-cycle reset pulse for the rest of the controller, such as its FIFOs and its control state. Other logic drives the event inputs as single-cycle pulses or as levels. A level input sets its status bit again on every cycle it stays high.

Top module: `intr_status_ctrl`

## Requirements
- R1: After reset the status, enable and global-enable registers are zero, `irq_o` and `core_rst_o` are low, and every register reads zero.
- R2: An event input bit i high at a rising edge sets status bit i at that edge. The bit assignments are: 0 arbitration lost, 1 transmit error or done, 2 transmit empty, 3 receive level reached, 4 bus idle, 5 addressed as target, 6 no longer addressed, 7 transmit half empty. The status register reads at offset 0x20, in bits 7:0.
- R3: A write to offset 0x20 clears each status bit whose write-data bit is one and leaves each bit whose write-data bit is zero unchanged.
- R4: When a status bit's event is high in the same cycle that a write clears that bit, the bit stays set.
- R5: The enable register at offset 0x28 holds write-data bits 7:0 and reads them back. `pending_o` equals status AND enable.
- R6: The global-enable register at offset 0x1C holds only write-data bit 31. It reads back in bit 31, and all its other bits read zero.
- R7: `irq_o` is high exactly when the global enable is set and `pending_o` is nonzero.
- R8: A write of 0x0000000A to offset 0x40 clears status, enable and global enable at that edge and raises `core_rst_o` for one cycle.
- R9: A write of any other value to offset 0x40 changes no register and leaves `core_rst_o` low. Offset 0x40 reads zero.
- R10: Writes to unmapped offsets change no register, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| evt_i | input | 8 | Event sources, one per status bit |
| pending_o | output | 8 | Status AND enable |
| irq_o | output | 1 | Interrupt line |
| core_rst_o | output | 1 | One-cycle reset pulse for the rest of the controller |

## Verification
A status bit that sticks, or that drops when it should hold, shows on the cycle after the event or the clear. It appears on `pending_o` and on a read of offset 0x20, and `irq_o` shows it too whenever that bit is enabled. The bench sweeps all 256 status patterns against several enable masks, with global enable both off and on. Any bit that is crossed or mis-gated therefore shows up as a wrong `irq_o` or `pending_o` value within one cycle. A reset-key decode that is too loose or too tight shows up as `core_rst_o` and cleared registers on the very next cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned OFF_GIE  = 32'h1C;
  localparam int unsigned OFF_STAT = 32'h20;
  localparam int unsigned OFF_IEN  = 32'h28;
  localparam int unsigned OFF_RST  = 32'h40;
  localparam int unsigned RST_KEY  = 32'h0000_000A;

  typedef enum logic [2:0] {
    EV_ARB_LOST  = 3'd0,
    EV_TX_DONE   = 3'd1,
    EV_TX_EMPTY  = 3'd2,
    EV_RX_LEVEL  = 3'd3,
    EV_BUS_IDLE  = 3'd4,
    EV_TGT_HIT   = 3'd5,
    EV_TGT_MISS  = 3'd6,
    EV_TX_HALF   = 3'd7
  } ev_idx_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 8,
  parameter int GIE_BIT = 31
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic              gie_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic              wr_ien_o,
  output logic              wr_gie_o,
  output logic              srst_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit_stat, hit_ien, hit_gie, hit_rst;

  assign hit_stat = addr_i == ADDR_W'(OFF_STAT);
  assign hit_ien  = addr_i == ADDR_W'(OFF_IEN);
  assign hit_gie  = addr_i == ADDR_W'(OFF_GIE);
  assign hit_rst  = addr_i == ADDR_W'(OFF_RST);

  assign clr_o    = (wr_en_i && hit_stat) ? wdata_i[NUM_SRC-1:0] : '0;
  assign wr_ien_o = wr_en_i && hit_ien;
  assign wr_gie_o = wr_en_i && hit_gie;
  assign srst_o   = wr_en_i && hit_rst && (wdata_i == DATA_W'(RST_KEY));

  always_comb begin
    rdata_o = '0;
    if (hit_stat)     rdata_o[NUM_SRC-1:0] = status_i;
    else if (hit_ien) rdata_o[NUM_SRC-1:0] = en_i;
    else if (hit_gie) rdata_o[GIE_BIT]     = gie_i;
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] stat_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        stat_q[i] <= 1'b0;
      else if (srst_i)    stat_q[i] <= 1'b0;
      else if (set_i[i])  stat_q[i] <= 1'b1;  // event beats clear
      else if (clr_i[i])  stat_q[i] <= 1'b0;
    end
  end

  assign status_o = stat_q;

  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && |set_i) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((stat_q & $past(clr_i & ~set_i)) == '0)); // R3
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && |(clr_i & set_i)) |=> ((stat_q & $past(clr_i & set_i)) == $past(clr_i & set_i))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && set_i == '0 && clr_i == '0) |=> $stable(stat_q)); // R3
endmodule

// File: rtl/irqc_enable.sv
module irqc_enable #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic               wr_ien_i,
  input  logic [NUM_SRC-1:0] ien_data_i,
  input  logic               wr_gie_i,
  input  logic               gie_data_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic               gie_o
);
  logic [NUM_SRC-1:0] en_q;
  logic               gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else if (srst_i) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (wr_ien_i) en_q  <= ien_data_i;
      if (wr_gie_i) gie_q <= gie_data_i;
    end
  end

  assign en_o  = en_q;
  assign gie_o = gie_q;

  AST_IEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ien_i && !srst_i) |=> (en_q == $past(ien_data_i))); // R5
  AST_GIE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gie_i && !srst_i) |=> (gie_q == $past(gie_data_i))); // R6
  AST_EN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ien_i && !wr_gie_i && !srst_i) |=> ($stable(en_q) && $stable(gie_q))); // R10
endmodule

// File: rtl/irqc_soft_reset.sv
module irqc_soft_reset (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  output logic core_rst_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= srst_i;
  end

  assign core_rst_o = pulse_q;

  AST_KEY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> pulse_q); // R8
  AST_NO_KEY_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_i |=> !pulse_q); // R9
endmodule

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 8,
  parameter int GIE_BIT = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [NUM_SRC-1:0] pending_o,
  output logic               irq_o,
  output logic               core_rst_o
);
  logic [NUM_SRC-1:0] status, en, clr;
  logic               gie, wr_ien, wr_gie, srst;

  irqc_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .GIE_BIT(GIE_BIT)
  ) u_decode (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .status_i(status),
    .en_i    (en),
    .gie_i   (gie),
    .clr_o   (clr),
    .wr_ien_o(wr_ien),
    .wr_gie_o(wr_gie),
    .srst_o  (srst),
    .rdata_o (rdata_o)
  );

  irqc_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst),
    .set_i   (evt_i),
    .clr_i   (clr),
    .status_o(status)
  );

  irqc_enable #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .wr_ien_i  (wr_ien),
    .ien_data_i(wdata_i[NUM_SRC-1:0]),
    .wr_gie_i  (wr_gie),
    .gie_data_i(wdata_i[GIE_BIT]),
    .en_o      (en),
    .gie_o     (gie)
  );

  irqc_soft_reset u_soft_reset (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .core_rst_o(core_rst_o)
  );

  assign pending_o = status & en;
  assign irq_o     = gie && (|pending_o);

  AST_KEY_CLEARS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (status == '0 && en == '0 && !gie && !irq_o)); // R8
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst || (wr_gie && !wdata_i[GIE_BIT])) |=> !irq_o); // R7
endmodule

// File: tb/intr_status_ctrl_bench.sv
`timescale 1ns/1ps
module intr_status_ctrl_bench;
  localparam logic [7:0] A_GIE = 8'h1C, A_STAT = 8'h20, A_IEN = 8'h28, A_RST = 8'h40, A_FREE = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0;
  logic [7:0]  pending;
  logic        irq, core_rst;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  intr_status_ctrl u_intr_status_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .pending_o(pending),
    .irq_o(irq), .core_rst_o(core_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  emask [6];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 core_rst", {31'd0, core_rst}, 0);
    chk("R1 pending", {24'd0, pending}, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_IEN, v);  chk("R1 enable", v, 0);
    rd(A_GIE, v);  chk("R1 gie", v, 0);
    rd(A_RST, v);  chk("R1 key reg", v, 0);

    // R2 each source to its own bit, R3 clear
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      rd(A_STAT, v); chk("R2 single source", v, 32'(1 << i));
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, v); chk("R3 clear all", v, 0);
    end

    // R3 partial clear, zero write keeps bits
    pulse(8'hFF);
    wr(A_STAT, 32'h0000_000F);
    rd(A_STAT, v); chk("R3 partial clear", v, 32'hF0);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R3 zero write keeps", v, 32'hF0);

    // R4 event beats clear in same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = A_STAT; wdata = 32'h0000_00F0; evt = 8'h30;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    rd(A_STAT, v); chk("R4 set wins", v, 32'h30);
    wr(A_STAT, 32'hFF);

    // R5 R6 R7 sweep over all status patterns
    for (int s = 0; s < 256; s++) begin
      wr(A_STAT, 32'hFF);
      pulse(8'(s));
      rd(A_STAT, v); chk("R2 pattern", v, 32'(s));
      emask[0] = 8'h00; emask[1] = 8'hFF; emask[2] = 8'(s);
      emask[3] = ~8'(s); emask[4] = 8'(1 << (s % 8)); emask[5] = 8'(s) ^ 8'h5A;
      for (int e = 0; e < 6; e++) begin
        wr(A_IEN, {24'hABCDEF, emask[e]});
        rd(A_IEN, v); chk("R5 enable readback", v, {24'd0, emask[e]});
        chk("R5 pending", {24'd0, pending}, {24'd0, 8'(s) & emask[e]});
        for (int g = 0; g < 2; g++) begin
          wr(A_GIE, {g[0], 31'h7FFF_FFFF});
          rd(A_GIE, v); chk("R6 gie readback", v, {g[0], 31'd0});
          chk("R7 irq", {31'd0, irq},
              {31'd0, (g == 1) && ((8'(s) & emask[e]) != 8'h00)});
        end
      end
    end

    // state for R9/R10: status 0x81, enable 0x01, gie 1
    wr(A_STAT, 32'hFF);
    pulse(8'h81);
    wr(A_IEN, 32'h01);
    wr(A_GIE, 32'h8000_0000);
    chk("R7 irq set", {31'd0, irq}, 1);

    // R10 unmapped
    wr(A_FREE, 32'hFFFF_FFFF);
    rd(A_FREE, v); chk("R10 unmapped read", v, 0);
    rd(A_STAT, v); chk("R10 status kept", v, 32'h81);
    rd(A_IEN, v);  chk("R10 enable kept", v, 32'h01);
    wr(8'h2C, 32'h0);
    rd(A_GIE, v);  chk("R10 gie kept", v, 32'h8000_0000);

    // R9 wrong keys
    wr(A_RST, 32'h0000_000B);
    chk("R9 no pulse 0xB", {31'd0, core_rst}, 0);
    wr(A_RST, 32'h0000_001A);
    chk("R9 no pulse 0x1A", {31'd0, core_rst}, 0);
    wr(A_RST, 32'h1000_000A);
    chk("R9 no pulse high bits", {31'd0, core_rst}, 0);
    rd(A_STAT, v); chk("R9 status kept", v, 32'h81);
    rd(A_IEN, v);  chk("R9 enable kept", v, 32'h01);
    rd(A_GIE, v);  chk("R9 gie kept", v, 32'h8000_0000);
    rd(A_RST, v);  chk("R9 key reads zero", v, 0);

    // R8 key
    wr(A_RST, 32'h0000_000A);
    chk("R8 pulse", {31'd0, core_rst}, 1);
    chk("R8 irq low", {31'd0, irq}, 0);
    rd(A_STAT, v); chk("R8 status cleared", v, 0);
    rd(A_IEN, v);  chk("R8 enable cleared", v, 0);
    rd(A_GIE, v);  chk("R8 gie cleared", v, 0);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'd0, core_rst}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule